// File: doc/BRIEF.md
# Clock Divisor Configuration Solver

This block turns a requested set of clock targets into divider settings for a three-stage clock tree. The stages are a core clock taken from a source, a bus clock derived from the divided core clock, and a peripheral clock derived from the bus clock. Four 32-bit frequencies in Hz form one request: the source, the core target, the bus ceiling and the peripheral ceiling. The solver answers with three divisors, the achieved frequencies, a flag for the voltage-scaling mode and a packed divider-control word. If no legal setting exists, it raises an invalid flag instead.

A request enters through a valid/ready handshake. `req_ready` is high only while the solver is idle. A request held on `req_valid` while the solver works is not taken, so the caller keeps it stable until it sees ready. There is no back-pressure on results. `done` pulses for one cycle, and the result outputs stay unchanged until the next `done`. All divisions by a run-time value go through one shared restoring divider that yields one quotient bit per cycle. Halving by a divisor of 2 is a shift.

Top module: `clkdiv_solver`

## Requirements
- R1: Before it divides, the solver lowers the bus ceiling to the core target whenever the ceiling is larger.
- R2: The core divisor is floor(source / core target), limited to the range 1 to 2 and reported on `core_div`. The divided core clock is source / core divisor.
- R3: The bus divisor is floor(divided core clock / bus ceiling), raised to 1 if it is 0. `bus_hz` = floor(divided core clock / bus divisor).
- R4: `scale_mode` is 1 exactly when the core target is strictly below the divided core clock. `core_act_hz` then equals `bus_hz`; otherwise it equals the divided core clock.
- R5: A bus divisor above 4 makes the result invalid. An invalid result drives every divisor, frequency, flag and control-word output to zero.
- R6: The peripheral divisor is 2 when `bus_hz` exceeds the peripheral ceiling, otherwise 1. It goes up by one more if bus / divisor still exceeds the ceiling. A value of 3 makes the result invalid.
- R7: `per_hz` = bus / peripheral divisor. `bus_div` = bus divisor × core divisor. `per_div` = peripheral divisor × bus divisor × core divisor.
- R8: `ctrl_word` has bits [1:0] = bus divisor − 1, bit 2 = 1 when the peripheral divisor is 2, and bit 3 = 1 when the core divisor is 2. All higher bits are 0.
- R9: A core target of 0, or a bus ceiling of 0, gives an invalid result without hanging the solver.
- R10: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the cycle of that request's `done`, and a new request can be accepted in that same cycle.
- R11: Each accepted request produces exactly one single-cycle `done`, fewer than 200 cycles after acceptance. The results stay unchanged until the next `done`.
- R12: After reset, `req_ready` is 1, and `done`, `invalid` and `ctrl_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Solver idle, request can be taken |
| src_hz | input | 32 | Source frequency |
| core_hz | input | 32 | Core target frequency |
| bus_max_hz | input | 32 | Bus ceiling |
| per_max_hz | input | 32 | Peripheral ceiling |
| done | output | 1 | One-cycle result strobe |
| invalid | output | 1 | No legal setting for the last request |
| scale_mode | output | 1 | Core runs from the bus clock |
| core_div | output | 2 | Core divisor |
| bus_div | output | 4 | Total bus divisor |
| per_div | output | 5 | Total peripheral divisor |
| bus_hz | output | 32 | Achieved bus frequency |
| per_hz | output | 32 | Achieved peripheral frequency |
| core_act_hz | output | 32 | Achieved core frequency |
| ctrl_word | output | 8 | Packed divider-control word |

## Verification
The overlap that matters is between finishing one solve and accepting the next request. The result strobe and the return of ready fall in the same cycle. The bench provokes this by holding the next request on `req_valid` while the current solve runs. The scoreboard must then still pop the earlier result at the strobe, take the new request at that edge, and later see a second, separate strobe. A separate test drives valid with conflicting operands while the solver is busy, and the bench judges it on three things: ready stays low, exactly one strobe arrives, and that strobe carries the first request's answer.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORE,
    ST_BUS,
    ST_BUSF,
    ST_PER,
    ST_FIN
  } solve_st_t;

  localparam int HDIV_LIMIT = 4;
endpackage

// File: rtl/clkdiv_divider.sv
module clkdiv_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]   rem_q, quo_q, a_q, b_q;
  logic [CW-1:0]  cnt_q;
  logic           run_q;
  logic [W:0]     shifted;
  logic [W-1:0]   diff;
  logic           fits;
  logic [2*W-1:0] prod;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = shifted >= {1'b0, b_q};
    diff    = shifted[W-1:0] - b_q;
    prod    = {{W{1'b0}}, quo_q} * {{W{1'b0}}, b_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        a_q   <= dividend;
        b_q   <= divisor;
        quo_q <= dividend;
        rem_q <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quot = quo_q;

  // quotient is the floor of the latched operands (R3)
  p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod <= {{W{1'b0}}, a_q}) &&
             (({{W{1'b0}}, a_q} - prod) < {{W{1'b0}}, b_q}));
endmodule

// File: rtl/clkdiv_pack.sv
module clkdiv_pack #(
  parameter int CTRL_W = 8
) (
  input  logic              core2,
  input  logic [2:0]        hdiv,
  input  logic              pdiv2,
  output logic [CTRL_W-1:0] ctrl,
  output logic [3:0]        bus_tot,
  output logic [4:0]        per_tot
);
  logic [1:0] hfield;

  always_comb begin
    hfield  = hdiv[1:0] - 2'd1;
    bus_tot = {1'b0, hdiv} << core2;
    per_tot = {1'b0, bus_tot} << pdiv2;
    ctrl    = '0;
    ctrl[1:0] = hfield;
    ctrl[2]   = pdiv2;
    ctrl[3]   = core2;
  end
endmodule

// File: rtl/clkdiv_solver.sv
module clkdiv_solver
  import clkdiv_pkg::*;
#(
  parameter int FW     = 32,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FW-1:0]     src_hz,
  input  logic [FW-1:0]     core_hz,
  input  logic [FW-1:0]     bus_max_hz,
  input  logic [FW-1:0]     per_max_hz,
  output logic              done,
  output logic              invalid,
  output logic              scale_mode,
  output logic [1:0]        core_div,
  output logic [3:0]        bus_div,
  output logic [4:0]        per_div,
  output logic [FW-1:0]     bus_hz,
  output logic [FW-1:0]     per_hz,
  output logic [FW-1:0]     core_act_hz,
  output logic [CTRL_W-1:0] ctrl_word
);
  solve_st_t st;
  logic [FW-1:0] src_r, core_r, hmax_r, pmax_r, acd_r, bus_r, per_r;
  logic          core2_r, pdiv2_r, scale_r, inv_r;
  logic [2:0]    hdiv_r;

  logic          div_go, div_done;
  logic [FW-1:0] div_a, div_b, div_q;

  logic          accept, core2_n, hdiv_bad, pd0_two, pd_three;
  logic [FW-1:0] hmax_in, acd_n, hq_n, half_bus, per_n;

  logic [CTRL_W-1:0] pk_ctrl;
  logic [3:0]        pk_bus;
  logic [4:0]        pk_per;

  assign req_ready = (st == ST_IDLE);

  always_comb begin
    accept   = req_valid && req_ready;
    hmax_in  = (bus_max_hz > core_hz) ? core_hz : bus_max_hz;
    core2_n  = div_q > FW'(1);
    acd_n    = core2_n ? (src_r >> 1) : src_r;
    hq_n     = (div_q == '0) ? FW'(1) : div_q;
    hdiv_bad = hq_n > FW'(HDIV_LIMIT);
    half_bus = bus_r >> 1;
    pd0_two  = bus_r > pmax_r;
    pd_three = pd0_two && (half_bus > pmax_r);
    per_n    = pd0_two ? half_bus : bus_r;
    div_go   = 1'b0;
    div_a    = src_hz;
    div_b    = core_hz;
    case (st)
      ST_IDLE: div_go = accept && (core_hz != '0) && (hmax_in != '0);
      ST_CORE: begin
        div_go = div_done;
        div_a  = acd_n;
        div_b  = hmax_r;
      end
      ST_BUS: begin
        div_go = div_done && !hdiv_bad;
        div_a  = acd_r;
        div_b  = hq_n;
      end
      default: ;
    endcase
  end

  clkdiv_divider #(.W(FW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_a), .divisor(div_b), .quot(div_q), .done(div_done)
  );

  clkdiv_pack #(.CTRL_W(CTRL_W)) u_pack (
    .core2(core2_r), .hdiv(hdiv_r), .pdiv2(pdiv2_r),
    .ctrl(pk_ctrl), .bus_tot(pk_bus), .per_tot(pk_per)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      src_r       <= '0;
      core_r      <= '0;
      hmax_r      <= '0;
      pmax_r      <= '0;
      acd_r       <= '0;
      bus_r       <= '0;
      per_r       <= '0;
      core2_r     <= 1'b0;
      pdiv2_r     <= 1'b0;
      scale_r     <= 1'b0;
      inv_r       <= 1'b0;
      hdiv_r      <= 3'd1;
      done        <= 1'b0;
      invalid     <= 1'b0;
      scale_mode  <= 1'b0;
      core_div    <= '0;
      bus_div     <= '0;
      per_div     <= '0;
      bus_hz      <= '0;
      per_hz      <= '0;
      core_act_hz <= '0;
      ctrl_word   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          src_r  <= src_hz;
          core_r <= core_hz;
          hmax_r <= hmax_in;
          pmax_r <= per_max_hz;
          inv_r  <= (core_hz == '0) || (hmax_in == '0);
          st     <= ((core_hz == '0) || (hmax_in == '0)) ? ST_FIN : ST_CORE;
        end
        ST_CORE: if (div_done) begin
          core2_r <= core2_n;
          acd_r   <= acd_n;
          st      <= ST_BUS;
        end
        ST_BUS: if (div_done) begin
          if (hdiv_bad) begin
            inv_r <= 1'b1;
            st    <= ST_FIN;
          end else begin
            hdiv_r <= hq_n[2:0];
            st     <= ST_BUSF;
          end
        end
        ST_BUSF: if (div_done) begin
          bus_r   <= div_q;
          scale_r <= core_r < acd_r;
          st      <= ST_PER;
        end
        ST_PER: begin
          pdiv2_r <= pd0_two;
          per_r   <= per_n;
          if (pd_three) inv_r <= 1'b1;
          st <= ST_FIN;
        end
        default: begin
          done        <= 1'b1;
          invalid     <= inv_r;
          scale_mode  <= inv_r ? 1'b0 : scale_r;
          core_div    <= inv_r ? 2'd0 : (core2_r ? 2'd2 : 2'd1);
          bus_div     <= inv_r ? 4'd0 : pk_bus;
          per_div     <= inv_r ? 5'd0 : pk_per;
          bus_hz      <= inv_r ? '0 : bus_r;
          per_hz      <= inv_r ? '0 : per_r;
          core_act_hz <= inv_r ? '0 : (scale_r ? bus_r : acd_r);
          ctrl_word   <= inv_r ? '0 : pk_ctrl;
          st          <= ST_IDLE;
        end
      endcase
    end
  end

  // R11: strobe lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: an accepted request makes the solver busy
  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R5: invalid results are cleared
  p_inv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (ctrl_word == '0 && bus_hz == '0 && core_div == 2'd0));
  // R4: scaling mode reports the bus clock as the core clock
  p_scale_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid && scale_mode) |-> (core_act_hz == bus_hz));
  // R2: core divisor limited to 1..2
  p_core_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid) |-> (core_div == 2'd1 || core_div == 2'd2));
endmodule

// File: tb/clkdiv_solver_test.sv
`timescale 1ns/1ps
module clkdiv_solver_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] src_hz = '0, core_hz = '0, bus_max_hz = '0, per_max_hz = '0;
  logic done, invalid, scale_mode;
  logic [1:0] core_div;
  logic [3:0] bus_div;
  logic [4:0] per_div;
  logic [31:0] bus_hz, per_hz, core_act_hz;
  logic [7:0] ctrl_word;

  always #2 clk = ~clk;

  clkdiv_solver uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src_hz(src_hz), .core_hz(core_hz), .bus_max_hz(bus_max_hz), .per_max_hz(per_max_hz),
    .done(done), .invalid(invalid), .scale_mode(scale_mode), .core_div(core_div),
    .bus_div(bus_div), .per_div(per_div), .bus_hz(bus_hz), .per_hz(per_hz),
    .core_act_hz(core_act_hz), .ctrl_word(ctrl_word)
  );

  typedef struct {
    string  tag;
    longint acc_cyc;
    bit     inv, scale;
    longint cdiv, btot, ptot, bus, per, core, ctrl;
  } exp_t;

  exp_t   sb[$];
  int     nchk = 0, nfail = 0, ndone = 0, npush = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(longint s, longint c, longint bm, longint pm, string tag);
    exp_t e;
    longint hm, cd, acd, hd, bus, pd;
    e = '{tag: tag, acc_cyc: 0, inv: 0, scale: 0, cdiv: 0, btot: 0, ptot: 0,
          bus: 0, per: 0, core: 0, ctrl: 0};
    hm = (bm > c) ? c : bm;
    if (c == 0 || hm == 0) begin e.inv = 1; return e; end
    cd = s / c;
    if (cd < 1) cd = 1;
    if (cd > 2) cd = 2;
    acd = s / cd;
    hd = acd / hm;
    if (hd < 1) hd = 1;
    if (hd > 4) begin e.inv = 1; return e; end
    bus = acd / hd;
    pd = (bus > pm) ? 2 : 1;
    if (bus / pd > pm) pd++;
    if (pd > 2) begin e.inv = 1; return e; end
    e.scale = c < acd;
    e.cdiv = cd; e.btot = hd * cd; e.ptot = pd * hd * cd;
    e.bus = bus; e.per = bus / pd; e.core = e.scale ? bus : acd;
    e.ctrl = (cd == 2 ? 8 : 0) + (pd != 1 ? 4 : 0) + (hd - 1);
    return e;
  endfunction

  // driver: call at a negedge; valid stays high on return
  task automatic send(input longint s, input longint c, input longint bm,
                      input longint pm, input string tag);
    exp_t e;
    src_hz = 32'(s); core_hz = 32'(c); bus_max_hz = 32'(bm); per_max_hz = 32'(pm);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e = model(s, c, bm, pm, tag);
    e.acc_cyc = cyc;
    sb.push_back(e);
    npush++;
    @(negedge clk);
  endtask

  task automatic drain();
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      ndone++;
      if (sb.size() == 0) begin
        chk(0, "R11", "unexpected done", 1, 0);
      end else begin
        e = sb.pop_front();
        chk(invalid == e.inv, e.tag, "invalid", invalid, e.inv);
        chk(cyc - e.acc_cyc < 200, "R11", "latency", cyc - e.acc_cyc, 199);
        if (!e.inv) begin
          chk(core_div == e.cdiv, "R2", "core_div", core_div, e.cdiv);
          chk(bus_hz == e.bus, "R3", "bus_hz", bus_hz, e.bus);
          chk(scale_mode == e.scale, "R4", "scale_mode", scale_mode, e.scale);
          chk(core_act_hz == e.core, "R4", "core_act_hz", core_act_hz, e.core);
          chk(per_hz == e.per, "R7", "per_hz", per_hz, e.per);
          chk(bus_div == e.btot, "R7", "bus_div", bus_div, e.btot);
          chk(per_div == e.ptot, "R7", "per_div", per_div, e.ptot);
          chk(ctrl_word == e.ctrl, "R8", "ctrl_word", ctrl_word, e.ctrl);
        end else begin
          chk(ctrl_word == 0 && per_hz == 0 && per_div == 0 && scale_mode == 0,
              "R5", "cleared outputs", ctrl_word, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && done == 0 && invalid == 0 && ctrl_word == 0,
        "R12", "reset state", {req_ready, done, invalid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);

    send(200000000, 200000000, 100000000, 50000000, "R6");  // ctrl 0x05
    drain();
    send(400000000, 100000000, 200000000, 100000000, "R1"); // cap, scale, ctrl 0x09
    drain();
    send(266000000, 133000000, 133000000, 66000000, "R6");  // peripheral /3 invalid
    drain();
    send(100000000, 100000000, 10000000, 50000000, "R5");   // bus divisor 10
    drain();
    send(100000000, 0, 50000000, 50000000, "R9");           // zero core target
    drain();
    send(100000000, 100000000, 0, 50000000, "R9");          // zero bus ceiling
    drain();
    send(50000000, 100000000, 100000000, 50000000, "R2");   // quotient 0 -> 1
    drain();
    send(100000000, 100000000, 30000000, 40000000, "R3");   // divisor 3, inexact
    drain();
    send(200000000, 200000000, 50000000, 25000000, "R7");   // totals 4 and 8
    drain();
    send(300000000, 300000000, 100000000, 100000000, "R3"); // divisor 3, exact
    drain();

    // R10: busy request is not taken
    send(200000000, 100000000, 100000000, 50000000, "R10");
    src_hz = 32'd5; core_hz = 32'd0; bus_max_hz = 32'd0; per_max_hz = 32'd0;
    for (int i = 0; i < 10; i++) begin
      chk(req_ready == 0, "R10", "ready while busy", req_ready, 0);
      @(negedge clk);
    end
    drain();
    chk(ndone == npush, "R10", "one result per accepted request", ndone, npush);

    // R11: results hold between strobes
    held = ctrl_word;
    repeat (20) @(negedge clk);
    chk(ctrl_word == held, "R11", "result held", ctrl_word, held);

    // R10/R11: back-to-back, next request taken in the done cycle
    send(400000000, 100000000, 200000000, 100000000, "R10");
    send(200000000, 200000000, 50000000, 25000000, "R10");
    send(100000000, 100000000, 30000000, 40000000, "R10");
    drain();
    chk(ndone == npush, "R11", "done count back-to-back", ndone, npush);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule